// File: doc/BRIEF.md
# Exception Stack Frame Builder

This block runs the stacking step of an unimplemented floating-point instruction trap. When the trigger arrives it latches the status word and the operand and address inputs. It produces the raised status word: supervisor set, both trace bits cleared, all other bits kept. It then writes a sixteen-byte exception frame into the area just below the supervisor stack pointer.

The frame holds five items. The first is the saved status word. The second is the address of the instruction that follows the faulting one. The third is a format/vector-offset word. The fourth is the operand's effective address. The fifth is the address of the faulting instruction itself. Writes go out through a valid/ready handshake as long words wherever the address is long-aligned, and as single words where it is not.

After the last write is accepted, a one-cycle done pulse is raised. It comes with the address of the vector table entry to fetch the handler from, and with the new stack pointer.

Top module: `excFrameBuilder`

## Requirements
- R1: After reset, `wrValid`, `done` and `busy` are low, and no write is offered while `busy` is low.
- R2: From the cycle after the trigger is taken, `newSr` equals the `curSr` sampled at the trigger with bit 13 (supervisor) set and bits 15 and 14 (trace) cleared; the other bits are unchanged.
- R3: `newSsp` equals the trigger-time `ssp` minus 16, and the writes cover exactly the bytes from `newSsp` to `newSsp`+15 (`ssp` is even).
- R4: The frame is stored big-endian from `newSsp` upward. The status word is at offset 0, the next-instruction PC (long) at 2, the format/offset word at 6, the effective address (long) at 8, and the faulting PC (long) at 12.
- R5: The format/offset word is 0x402C: format 4 in bits 15:12 and the vector offset 11×4 in bits 11:0.
- R6: When `eaNoAddr` is high (immediate or register-direct operand), the effective-address field is zero; otherwise it is `effAddr`.
- R7: When `newSsp` is long-aligned, the frame goes out as four long writes (`wrLong`=1) at ascending addresses.
- R8: When `newSsp` has bit 1 set, the frame goes out as a word write, three long writes and a word write, at ascending addresses. Word data sits in `wrData[15:0]`, with the upper half zero.
- R9: While `wrValid` is high and `wrReady` is low, `wrValid`, `wrAddr`, `wrData` and `wrLong` hold their values.
- R10: In the cycle after the last write is accepted, `done` is high for exactly one cycle with `wrValid` low, and `vecAddr` equals `vbr`+0x2C.
- R11: A trigger while `busy` is high is ignored, and input changes after the trigger do not alter the frame being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Start a trap frame (taken when idle) |
| curSr | input | 16 | Current status word |
| nextPc | input | 32 | Address of the instruction after the faulting one |
| faultPc | input | 32 | Address of the faulting instruction |
| effAddr | input | 32 | Computed operand address |
| eaNoAddr | input | 1 | Operand is immediate or register-direct |
| ssp | input | 32 | Supervisor stack pointer before stacking |
| vbr | input | 32 | Vector table base |
| wrReady | input | 1 | Write accepted this cycle |
| wrValid | output | 1 | Write request |
| wrAddr | output | 32 | Write byte address |
| wrData | output | 32 | Write data |
| wrLong | output | 1 | 1 = long-word write, 0 = word write |
| busy | output | 1 | Frame sequence in progress |
| newSr | output | 16 | Status word after the mode change |
| newSsp | output | 32 | Stack pointer after stacking |
| done | output | 1 | One-cycle end-of-frame pulse |
| vecAddr | output | 32 | Handler vector fetch address |

## Verification
The frame is built from a long-aligned stack pointer and from one with only bit 1 set. This separates the four-long packing from the word/long/word split and shows whether halfwords straddle the boundaries correctly. Runs with and without the no-address operand class show whether the effective-address field is forced to zero. A status word with trace set and supervisor clear, and one with every other bit set, show that only the three mode bits change. Stall patterns on the ready input check that requests hold. A second trigger, together with altered inputs during the frame, shows that the latched snapshot is protected.

// File: rtl/excFramePkg.sv
package excFramePkg;
  typedef struct packed {
    logic capture;
    logic advance;
  } frameStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_DONE} frameState_t;
endpackage

// File: rtl/frameDatapath.sv
module frameDatapath
  import excFramePkg::*;
#(
  parameter int FMT_NUM = 4,
  parameter int VEC_NUM = 11,
  parameter int HALF_CNT = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  frameStrobe_t strb,
  input  logic [15:0]  curSr,
  input  logic [31:0]  nextPc,
  input  logic [31:0]  faultPc,
  input  logic [31:0]  effAddr,
  input  logic         eaNoAddr,
  input  logic [31:0]  ssp,
  input  logic [31:0]  vbr,
  output logic [31:0]  wrAddr,
  output logic [31:0]  wrData,
  output logic         wrLong,
  output logic         lastBeat,
  output logic [15:0]  newSr,
  output logic [31:0]  newSsp,
  output logic [31:0]  vecAddr
);
  localparam int IDX_W = $clog2(HALF_CNT) + 1;
  localparam int SEL_W = $clog2(HALF_CNT);
  localparam logic [31:0] FRAME_BYTES = 32'(HALF_CNT * 2);
  localparam logic [31:0] VEC_OFS = 32'(VEC_NUM * 4);
  localparam logic [15:0] FV_WORD = {4'(FMT_NUM), VEC_OFS[11:0]};
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HALF_CNT);

  logic [15:0] halfReg [HALF_CNT];
  logic [IDX_W-1:0] idx;
  logic [31:0] ptr;
  logic [31:0] eaField;
  logic [SEL_W-1:0] selLo, selHi;
  logic [IDX_W-1:0] step;

  assign eaField = eaNoAddr ? 32'h0 : effAddr;
  assign selLo = idx[SEL_W-1:0];
  assign selHi = selLo + SEL_W'(1);

  assign wrLong = (ptr[1] == 1'b0) && (idx <= LAST_IDX - IDX_W'(2));
  assign step = wrLong ? IDX_W'(2) : IDX_W'(1);
  assign wrData = wrLong ? {halfReg[selLo], halfReg[selHi]} : {16'h0, halfReg[selLo]};
  assign wrAddr = ptr;
  assign lastBeat = (idx + step) == LAST_IDX;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < HALF_CNT; i++) halfReg[i] <= '0;
      idx <= '0;
      ptr <= '0;
      newSr <= '0;
      newSsp <= '0;
      vecAddr <= '0;
    end else if (strb.capture) begin
      halfReg[0] <= curSr;
      halfReg[1] <= nextPc[31:16];
      halfReg[2] <= nextPc[15:0];
      halfReg[3] <= FV_WORD;
      halfReg[4] <= eaField[31:16];
      halfReg[5] <= eaField[15:0];
      halfReg[6] <= faultPc[31:16];
      halfReg[7] <= faultPc[15:0];
      newSr <= {2'b00, 1'b1, curSr[12:0]};
      newSsp <= ssp - FRAME_BYTES;
      ptr <= ssp - FRAME_BYTES;
      idx <= '0;
      vecAddr <= vbr + VEC_OFS;
    end else if (strb.advance) begin
      idx <= idx + step;
      ptr <= ptr + {{(32-IDX_W-1){1'b0}}, step, 1'b0};
    end
  end
endmodule

// File: rtl/frameControl.sv
module frameControl
  import excFramePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         trig,
  input  logic         wrReady,
  input  logic         lastBeat,
  output frameStrobe_t strb,
  output logic         wrValid,
  output logic         done,
  output logic         busy
);
  frameState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb = '0;
    unique case (state)
      ST_IDLE: if (trig) begin
        strb.capture = 1'b1;
        stateNext = ST_WRITE;
      end
      ST_WRITE: if (wrReady) begin
        strb.advance = 1'b1;
        if (lastBeat) stateNext = ST_DONE;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end

  assign wrValid = (state == ST_WRITE);
  assign done = (state == ST_DONE);
  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/excFrameBuilder.sv
module excFrameBuilder
  import excFramePkg::*;
#(
  parameter int FMT_NUM = 4,
  parameter int VEC_NUM = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        trig,
  input  logic [15:0] curSr,
  input  logic [31:0] nextPc,
  input  logic [31:0] faultPc,
  input  logic [31:0] effAddr,
  input  logic        eaNoAddr,
  input  logic [31:0] ssp,
  input  logic [31:0] vbr,
  input  logic        wrReady,
  output logic        wrValid,
  output logic [31:0] wrAddr,
  output logic [31:0] wrData,
  output logic        wrLong,
  output logic        busy,
  output logic [15:0] newSr,
  output logic [31:0] newSsp,
  output logic        done,
  output logic [31:0] vecAddr
);
  frameStrobe_t strb;
  logic lastBeat;

  frameControl u_ctrl (
    .clk(clk), .rstN(rstN), .trig(trig), .wrReady(wrReady), .lastBeat(lastBeat),
    .strb(strb), .wrValid(wrValid), .done(done), .busy(busy)
  );

  frameDatapath #(.FMT_NUM(FMT_NUM), .VEC_NUM(VEC_NUM), .HALF_CNT(8)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .curSr(curSr), .nextPc(nextPc),
    .faultPc(faultPc), .effAddr(effAddr), .eaNoAddr(eaNoAddr), .ssp(ssp), .vbr(vbr),
    .wrAddr(wrAddr), .wrData(wrData), .wrLong(wrLong), .lastBeat(lastBeat),
    .newSr(newSr), .newSsp(newSsp), .vecAddr(vecAddr)
  );
endmodule

// File: rtl/excFrameChecker.sv
module excFrameChecker (
  input logic        clk,
  input logic        rstN,
  input logic        wrValid,
  input logic        wrReady,
  input logic [31:0] wrAddr,
  input logic [31:0] wrData,
  input logic        wrLong,
  input logic        busy,
  input logic        done,
  input logic [15:0] newSr
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN) !busy |-> !wrValid && !done); // R1
  AST_MODE_BITS: assert property (@(posedge clk) disable iff (!rstN) wrValid |-> newSr[13] && !newSr[15] && !newSr[14]); // R2
  AST_LONG_ALIGNED: assert property (@(posedge clk) disable iff (!rstN) (wrValid && wrLong) |-> wrAddr[1:0] == 2'b00); // R7
  AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN) (wrValid && !wrLong) |-> wrData[31:16] == 16'h0); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN) (wrValid && !wrReady) |=> wrValid && $stable(wrAddr) && $stable(wrData) && $stable(wrLong)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R10
  AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN) done |-> !wrValid); // R10
endmodule

bind excFrameBuilder excFrameChecker u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr),
  .wrData(wrData), .wrLong(wrLong), .busy(busy), .done(done), .newSr(newSr)
);

// File: tb/test_excFrameBuilder.sv
`timescale 1ns/1ps
module test_excFrameBuilder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trig = 1'b0;
  logic [15:0] curSr = '0;
  logic [31:0] nextPc = '0, faultPc = '0, effAddr = '0, ssp = '0, vbr = '0;
  logic eaNoAddr = 1'b0;
  logic wrReady = 1'b0;
  logic wrValid, wrLong, busy, done;
  logic [31:0] wrAddr, wrData, newSsp, vecAddr;
  logic [15:0] newSr;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    logic        isLong;
  } wrItem_t;
  wrItem_t expQ[$];

  always #2 clk = ~clk;

  excFrameBuilder i_excFrameBuilder (
    .clk(clk), .rstN(rstN), .trig(trig), .curSr(curSr), .nextPc(nextPc),
    .faultPc(faultPc), .effAddr(effAddr), .eaNoAddr(eaNoAddr), .ssp(ssp), .vbr(vbr),
    .wrReady(wrReady), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .wrLong(wrLong), .busy(busy), .newSr(newSr), .newSsp(newSsp), .done(done),
    .vecAddr(vecAddr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: byte image of the frame, then long-first packing by address.
  task automatic buildModel(input logic [15:0] sr, input logic [31:0] npc, input logic [31:0] fpc,
                            input logic [31:0] ea, input bit noAddr, input logic [31:0] sp);
    byte unsigned img[16];
    logic [31:0] eaF;
    logic [31:0] base;
    int off;
    eaF = noAddr ? 32'h0 : ea;
    base = sp - 32'd16;
    img[0] = sr[15:8];  img[1] = sr[7:0];
    for (int k = 0; k < 4; k++) begin
      img[2 + k]  = npc[31 - 8*k -: 8];
      img[8 + k]  = eaF[31 - 8*k -: 8];
      img[12 + k] = fpc[31 - 8*k -: 8];
    end
    img[6] = 8'h40; img[7] = 8'h2C;
    expQ.delete();
    off = 0;
    while (off < 16) begin
      wrItem_t it;
      it.addr = base + 32'(off);
      if (it.addr[1:0] == 2'b00 && off <= 12) begin
        it.isLong = 1'b1;
        it.data = {img[off], img[off+1], img[off+2], img[off+3]};
        off += 4;
      end else begin
        it.isLong = 1'b0;
        it.data = {16'h0, img[off], img[off+1]};
        off += 2;
      end
      expQ.push_back(it);
    end
  endtask

  task automatic runFrame(input logic [15:0] sr, input logic [31:0] npc, input logic [31:0] fpc,
                          input logic [31:0] ea, input bit noAddr, input logic [31:0] sp,
                          input logic [31:0] vb, input logic [3:0] readyPat, input bit inject,
                          input int expWrites, input string tag);
    logic [15:0] expSr;
    int c;
    buildModel(sr, npc, fpc, ea, noAddr, sp);
    expSr = (sr & 16'h3FFF) | 16'h2000;
    chk(expQ.size() == expWrites, {tag, " R7 R8 write count"}, 32'(expQ.size()), 32'(expWrites));
    @(negedge clk);
    curSr = sr; nextPc = npc; faultPc = fpc; effAddr = ea; eaNoAddr = noAddr; ssp = sp; vbr = vb;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    // R11: scramble inputs after the trigger
    curSr = ~sr; nextPc = ~npc; faultPc = ~fpc; effAddr = ~ea; eaNoAddr = ~noAddr;
    ssp = sp + 32'h100; vbr = ~vb;
    chk(newSr == expSr, {tag, " R2 newSr"}, 32'(newSr), 32'(expSr));
    chk(newSsp == sp - 32'd16, {tag, " R3 newSsp"}, newSsp, sp - 32'd16);
    c = 0;
    while (expQ.size() > 0 && c < 200) begin
      chk(wrValid == 1'b1, {tag, " R9 wrValid"}, 32'(wrValid), 32'd1);
      chk(done == 1'b0, {tag, " R10 done early"}, 32'(done), 32'd0);
      chk(wrAddr == expQ[0].addr, {tag, " R3 R7 R8 wrAddr"}, wrAddr, expQ[0].addr);
      chk(wrData == expQ[0].data, {tag, " R4 R5 R6 wrData"}, wrData, expQ[0].data);
      chk(wrLong == expQ[0].isLong, {tag, " R7 R8 wrLong"}, 32'(wrLong), 32'(expQ[0].isLong));
      wrReady = readyPat[c % 4];
      if (inject && c == 1) trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      if (wrReady) void'(expQ.pop_front());
      wrReady = 1'b0;
      c++;
    end
    chk(done == 1'b1, {tag, " R10 done pulse"}, 32'(done), 32'd1);
    chk(wrValid == 1'b0, {tag, " R10 no write at done"}, 32'(wrValid), 32'd0);
    chk(vecAddr == vb + 32'h2C, {tag, " R10 vecAddr"}, vecAddr, vb + 32'h2C);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R10 done single"}, 32'(done), 32'd0);
    chk(busy == 1'b0, {tag, " R11 idle after frame"}, 32'(busy), 32'd0);
    chk(wrValid == 1'b0, {tag, " R1 quiet idle"}, 32'(wrValid), 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(wrValid == 1'b0, "R1 reset wrValid", 32'(wrValid), 32'd0);
    chk(done == 1'b0, "R1 reset done", 32'(done), 32'd0);
    chk(busy == 1'b0, "R1 reset busy", 32'(busy), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 idle after reset", 32'(busy), 32'd0);

    runFrame(16'h8700, 32'h0010_2004, 32'h0010_2000, 32'hCAFE_0124, 1'b0,
             32'h0000_8000, 32'h0000_0000, 4'b1111, 1'b0, 4, "aligned");
    runFrame(16'h5F1F, 32'h1234_5678, 32'h1234_5672, 32'hDEAD_BEEF, 1'b0,
             32'h0000_7FF2, 32'h0004_0000, 4'b0101, 1'b0, 5, "wordAligned");
    runFrame(16'hC000, 32'hAAAA_5554, 32'hAAAA_5550, 32'h9999_8888, 1'b1,
             32'h0001_0000, 32'h00F0_0100, 4'b0110, 1'b1, 4, "R6 noAddr");
    runFrame(16'hDFFF, 32'h0000_0102, 32'h0000_00FE, 32'h7654_3210, 1'b1,
             32'h0002_000A, 32'hFFFF_FF00, 4'b1000, 1'b1, 5, "R11 busyTrig");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule